// File: doc/BRIEF.md
# UART Fractional Baud Tick Generator

This block produces the 16x-oversampling clock enable that drives the transmit and receive shift logic of a 16550-style UART. An integer divisor sets the basic tick period in clock cycles. A fractional stage then stretches that period by a factor of (MUL + DIVADD) / MUL on average, which lets the UART reach baud rates that no whole-number divisor can hit. The output `tick` is a clock enable that is one cycle wide. Its average rate is clk / divisor × MUL / (MUL + DIVADD), which gives a baud rate of clk / (16 × divisor) × MUL / (MUL + DIVADD).

Software programs the block through a byte-wide write port. One select value writes each byte of the divisor and one writes the fractional register. A phase accumulator adds DIVADD each time an integer period ends with a tick. When the accumulator reaches MUL, it subtracts MUL and the next integer period passes without a tick. New settings are taken only when the current period ends, so a reprogramming never produces a shortened period.

Top module: `baud_frac_gen`

## Requirements
- R1: With the fractional register at its reset value, a nonzero divisor D gives ticks exactly D clock cycles apart. The divisor low byte is written with select 0 and the high byte with select 1.
- R2: The fractional register is written with select 2. Bits [7:4] hold MUL and bits [3:0] hold DIVADD. When 1 ≤ MUL ≤ 15 and DIVADD < MUL, every gap between ticks is D or 2D cycles, and any MUL consecutive gaps add up to exactly D × (MUL + DIVADD) cycles.
- R3: A fractional value with MUL = 0 or with DIVADD ≥ MUL applies no correction: ticks come every D cycles.
- R4: A divisor of 0 stops the ticks once the period in progress has ended. No tick appears while the divisor is 0.
- R5: Writes take effect only at the end of the integer period in progress. The gap that follows a write keeps the old length, and the later gaps use the new setting.
- R6: For D ≥ 2 the tick is high for one clock cycle and low in the cycle after it. For D = 1 with no correction, the tick is high in every cycle.
- R7: After synchronous reset, the divisor is 0, the fractional register is 0x10 (MUL = 1, DIVADD = 0), the accumulator is cleared and `tick` is low.
- R8: The full 16-bit divisor is used. A value with a nonzero high byte gives the gap set by both bytes.
- R9: A write with select 3 changes nothing. The tick spacing stays the same afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 divisor low, 1 divisor high, 2 fractional, 3 unused |
| wr_data | input | 8 | Write data byte |
| tick | output | 1 | 16x baud clock enable, one cycle wide |

## Verification
The tick stream is measured as a series of gaps between ticks. Plain integer divisors (small, single-cycle and two-byte) show that the counter period is exact. Three fractional settings are used, one of which is the extreme MUL = 15, DIVADD = 14. For each, the check looks at both the allowed gap values and the sum over a window of MUL gaps, which separates a correct accumulator from one that skips too often or at the wrong modulus. Invalid fractional codes and select-3 writes must leave the integer spacing unchanged. A divisor change written just after a tick must show one gap of the old length before the new one. This tells a reload at the end of the period apart from an immediate load that truncates it.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef struct packed {
    logic [3:0] mul;
    logic [3:0] add;
  } frac_t;

  localparam logic [7:0] FRAC_RESET = 8'h10;

  function automatic logic frac_ok(input frac_t f);
    return (f.mul != 4'd0) && (f.add < f.mul);
  endfunction

endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [7:0]       wr_data,
  output logic [DIV_W-1:0] shd_div,
  output frac_t            shd_frac
);
  localparam int NBYTES = DIV_W / 8;
  localparam logic [SEL_W-1:0] FRAC_SEL = SEL_W'(NBYTES);

  // one shadow register per divisor byte lane
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) lane_q <= 8'h00;
      else if (wr_en && wr_sel == SEL_W'(b)) lane_q <= wr_data;
    end
    assign shd_div[8*b +: 8] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (rst) shd_frac <= frac_t'(FRAC_RESET);
    else if (wr_en && wr_sel == FRAC_SEL) shd_frac <= frac_t'(wr_data);
  end

endmodule

// File: rtl/baud_count.sv
module baud_count #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] shd_div,
  output logic [DIV_W-1:0] act_div,
  output logic             expire,
  output logic             reload
);
  logic [DIV_W-1:0] cnt;

  assign expire = (act_div != '0) && (cnt == act_div - 1'b1);
  // an idle counter reloads every cycle so a new divisor starts promptly
  assign reload = expire || (act_div == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_div <= '0;
    end else if (reload) begin
      cnt     <= '0;
      act_div <= shd_div;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    (act_div != '0) |-> (cnt < act_div))
    else $error("counter beyond active divisor");

endmodule

// File: rtl/baud_phase.sv
module baud_phase
  import baud_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  expire,
  input  logic  reload,
  input  frac_t shd_frac,
  output logic  fire
);
  frac_t      act_frac;
  logic [4:0] acc;
  logic       skip_q;
  logic [4:0] eff_mul, eff_add, sum;
  logic       ovf;

  always_comb begin
    if (frac_ok(act_frac)) begin
      eff_mul = {1'b0, act_frac.mul};
      eff_add = {1'b0, act_frac.add};
    end else begin
      eff_mul = 5'd1;
      eff_add = 5'd0;
    end
    sum = acc + eff_add;
    ovf = (sum >= eff_mul);
  end

  assign fire = expire && !skip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_frac <= frac_t'(FRAC_RESET);
      acc      <= '0;
      skip_q   <= 1'b0;
    end else begin
      if (expire) begin
        if (skip_q) begin
          skip_q <= 1'b0;
        end else begin
          acc    <= ovf ? (sum - eff_mul) : sum;
          skip_q <= ovf;
        end
      end
      if (reload) begin
        act_frac <= shd_frac;
        if (shd_frac != act_frac) begin
          acc    <= '0;
          skip_q <= 1'b0;
        end
      end
    end
  end

  a_r2_acc_below_mul: assert property (@(posedge clk) disable iff (rst)
    acc < eff_mul)
    else $error("phase accumulator not below MUL");

  a_r2_skip_one_period: assert property (@(posedge clk) disable iff (rst)
    (expire && skip_q) |=> !skip_q)
    else $error("skip lasted more than one period");

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
  import baud_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [7:0]       wr_data,
  output logic             tick
);
  logic [DIV_W-1:0] shd_div, act_div;
  frac_t            shd_frac;
  logic             expire, reload, fire;

  baud_regs #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .shd_div(shd_div), .shd_frac(shd_frac)
  );

  baud_count #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .shd_div(shd_div),
    .act_div(act_div), .expire(expire), .reload(reload)
  );

  baud_phase u_phase (
    .clk(clk), .rst(rst), .expire(expire), .reload(reload),
    .shd_frac(shd_frac), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= fire;
  end

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (act_div == '0) |=> !tick)
    else $error("tick while divisor is zero");

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (tick && act_div != DIV_W'(1)) |=> !tick)
    else $error("tick wider than one cycle");

endmodule

// File: tb/tb_baud_frac_gen.sv
module tb_baud_frac_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tick;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  baud_frac_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick(tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_div(input int d);
    wr(2'd0, d[7:0]);
    wr(2'd1, d[15:8]);
  endtask

  // waits at negedges until tick is seen high
  task automatic sync_tick(input string req);
    int n = 0;
    do begin
      @(negedge clk); n++;
    end while (!tick && n < 3000);
    if (!tick) check(1'b0, req, n, 0);
  endtask

  // cycles from the current tick to the next one
  task automatic get_gap(input string req, output int g);
    g = 0;
    do begin
      @(negedge clk); g++;
    end while (!tick && g < 3000);
    if (!tick) check(1'b0, req, g, 0);
  endtask

  task automatic settle(input string req);
    int g;
    sync_tick(req);
    for (int i = 0; i < 3; i++) get_gap(req, g);
  endtask

  task automatic t_reset();
    int seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(seen == 0, "R7 reset idle", seen, 0);
  endtask

  task automatic t_integer();
    int g;
    set_div(5);
    settle("R1");
    for (int i = 0; i < 4; i++) begin
      get_gap("R1", g);
      check(g == 5, "R1 integer gap", g, 5);
    end
  endtask

  task automatic t_wide();
    int g;
    set_div(16'h0102);
    settle("R8");
    get_gap("R8", g);
    check(g == 258, "R8 two-byte divisor gap", g, 258);
  endtask

  task automatic t_frac(input int d, input int mul, input int add);
    int g, sum, bad;
    set_div(d);
    wr(2'd2, 8'((mul << 4) | add));
    settle("R2");
    sum = 0; bad = 0;
    for (int i = 0; i < mul; i++) begin
      get_gap("R2", g);
      sum += g;
      if (g != d && g != 2 * d) bad++;
    end
    check(bad == 0, "R2 gap is D or 2D", bad, 0);
    check(sum == d * (mul + add), "R2 window sum", sum, d * (mul + add));
  endtask

  task automatic t_invalid(input logic [7:0] code);
    int g;
    set_div(5);
    wr(2'd2, code);
    settle("R3");
    for (int i = 0; i < 3; i++) begin
      get_gap("R3", g);
      check(g == 5, "R3 invalid fraction ignored", g, 5);
    end
  endtask

  task automatic t_sel3();
    int g;
    wr(2'd2, 8'h10);
    set_div(6);
    settle("R9");
    wr(2'd3, 8'hFF);
    sync_tick("R9");
    for (int i = 0; i < 3; i++) begin
      get_gap("R9", g);
      check(g == 6, "R9 select 3 ignored", g, 6);
    end
  endtask

  task automatic t_midwrite();
    int g;
    set_div(10);
    settle("R5");
    // tick just seen: reprogram inside the running period
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'd3;
    @(negedge clk);
    wr_en = 1'b0;
    g = 1;
    while (!tick && g < 3000) begin
      @(negedge clk); g++;
    end
    check(g == 10, "R5 running period kept", g, 10);
    get_gap("R5", g);
    check(g == 3, "R5 new divisor applied", g, 3);
  endtask

  task automatic t_one();
    int high = 0;
    set_div(1);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick) high++;
    end
    check(high == 20, "R6 divisor 1 tick every cycle", high, 20);
  endtask

  task automatic t_pulse();
    int wide = 0;
    set_div(4);
    settle("R6");
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tick) begin
        @(negedge clk);
        if (tick) wide++;
      end
    end
    check(wide == 0, "R6 one-cycle pulse", wide, 0);
  endtask

  task automatic t_disable();
    int seen = 0;
    set_div(4);
    settle("R4");
    set_div(0);
    repeat (20) @(negedge clk);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(seen == 0, "R4 divisor zero stops ticks", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_integer();
    t_wide();
    t_frac(4, 3, 1);
    t_frac(3, 2, 1);
    t_frac(2, 15, 14);
    t_invalid(8'h22);
    t_invalid(8'h03);
    t_sel3();
    t_midwrite();
    t_pulse();
    t_one();
    t_disable();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule